// File: doc/BRIEF.md
# Lane-Confined SIMD Shifter with Byte Align

This block is a registered 64-bit SIMD shift unit. One operand is split into lanes of 16, 32 or 64 bits, and each lane is shifted left logically, shifted right logically, shifted right arithmetically or rotated right by the same amount. No bit ever moves from one lane into a neighbouring lane. Each lane also produces a negative flag and a zero flag, and these are packed into a 32-bit flag word whose layout depends on the lane size.

A second function treats the two operands as one 128-bit value, with the second operand above the first. It extracts the 64 bits that start at a chosen byte offset. This gives an unaligned-load merge, or a funnel extract between two registers.

The datapath is purely combinational. When a request is accepted, the result and the flags are captured on the clock edge, and a valid strobe is raised in the cycle after that.

Top module: `simd_lane_shifter`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `result`, `laneFlags` and `outValid` are all zero.
- R2: An accepted request loads `result` and `laneFlags` at the clock edge where `inValid` is high, and `outValid` is high during the next cycle only. When no request is accepted, both registers keep their values and `outValid` is low.
- R3: Operation code 0 shifts each lane left logically and fills with zeros. Bits never pass into the next lane. An amount equal to the lane width or larger gives a zero lane.
- R4: Operation code 1 shifts each lane right logically and fills with zeros. Bits never pass into the next lane. An amount equal to the lane width or larger gives a zero lane.
- R5: Operation code 2 shifts each lane right arithmetically, with the sign replicated from the lane's top bit. An amount equal to the lane width or larger fills the lane with copies of its sign.
- R6: Operation code 3 rotates each lane right. Only the amount modulo the lane width counts, so an amount of 20 on 16-bit lanes acts like 4.
- R7: `laneSel` picks the lane size: 0 gives 16 bits, 1 gives 32 bits, and both 2 and 3 give one 64-bit lane.
- R8: Operation code 4 (align) returns `(opX >> 8k) | (opY << (64 - 8k))`, where k = `amount[2:0]`. The upper amount bits are ignored. When k is 0 the result is `opX` unchanged.
- R9: After a shift or rotate, lane i drives its negative flag (the lane's top bit) at bit S·(i+1)−1 of `laneFlags` and its zero flag at bit S·(i+1)−2, where S = 32 / lane count (8, 16 or 32). All other flag bits are zero.
- R10: An align request writes an all-zero `laneFlags`.
- R11: Operation codes 5 to 7 are reserved. A request that carries one leaves `result` and `laneFlags` unchanged and does not raise `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 3 | Operation: 0 shl, 1 shr, 2 sar, 3 ror, 4 align |
| laneSel | input | 2 | Lane size: 0=16, 1=32, 2/3=64 |
| amount | input | 8 | Shift or rotate count; low 3 bits give the align byte offset |
| opX | input | 64 | Shifted operand / low half of the align pair |
| opY | input | 64 | High half of the align pair |
| result | output | 64 | Registered result |
| laneFlags | output | 32 | Registered per-lane N/Z flag word |
| outValid | output | 1 | High the cycle after an accepted request |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath and an 8-bit amount. The 8-bit amount reaches counts far beyond every lane width, so oversize logical and arithmetic shifts and rotate wrap-around can be driven on all three lane sizes. The same width lets the bench set upper amount bits that the align function must ignore. Lane-boundary patterns place set bits right at each seam, so any leakage between lanes shows up in the result.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROR = 3'd3,
    OP_ALN = 3'd4
  } shOp_e;

  localparam logic [1:0] KIND_SHL = 2'd0;
  localparam logic [1:0] KIND_SHR = 2'd1;
  localparam logic [1:0] KIND_SAR = 2'd2;
  localparam logic [1:0] KIND_ROR = 2'd3;

  localparam int LANE_KINDS = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       align;
    logic [1:0] kind;
    logic [1:0] laneIdx;
  } shStrobe_t;

endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] opSel,
  input  logic [1:0] laneSel,
  output shStrobe_t  strb
);

  logic legalOp;

  always_comb begin
    legalOp      = (opSel <= OP_ALN);
    strb.load    = inValid && legalOp;
    strb.align   = (opSel == OP_ALN);
    strb.kind    = opSel[1:0];
    strb.laneIdx = (laneSel == 2'd3) ? 2'd2 : laneSel;
  end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  parameter int AMT_W  = 8,
  parameter int FLAG_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [AMT_W-1:0]  amt,
  input  logic [1:0]        kind,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] nz
);
  import shifter_pkg::*;

  localparam int LANES  = DATA_W / LANE_W;
  localparam int STRIDE = FLAG_W / LANES;
  localparam int ROT_W  = $clog2(LANE_W);
  localparam logic [ROT_W:0] LW = (ROT_W + 1)'(LANE_W);

  logic [ROT_W-1:0] rot;
  assign rot = amt[ROT_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] laneIn;
    logic [LANE_W-1:0] laneOut;
    assign laneIn = opnd[i*LANE_W +: LANE_W];

    always_comb begin
      unique case (kind)
        KIND_SHL: laneOut = laneIn << amt;
        KIND_SHR: laneOut = laneIn >> amt;
        KIND_SAR: laneOut = $signed(laneIn) >>> amt;
        default:  laneOut = (laneIn >> rot) | (laneIn << (LW - {1'b0, rot}));
      endcase
    end

    assign res[i*LANE_W +: LANE_W] = laneOut;
    assign nz[i*STRIDE +: STRIDE]  = {laneOut[LANE_W-1], ~|laneOut, {(STRIDE-2){1'b0}}};
  end

endmodule

// File: rtl/shifter_datapath.sv
module shifter_datapath
  import shifter_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         strb,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] resQ,
  output logic [FLAG_W-1:0] nzQ,
  output logic              validQ
);

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int SH_W  = OFF_W + 3;
  localparam logic [SH_W:0] FULL = (SH_W + 1)'(DATA_W);

  logic [DATA_W-1:0] laneRes [LANE_KINDS];
  logic [FLAG_W-1:0] laneNz  [LANE_KINDS];

  for (genvar s = 0; s < LANE_KINDS; s++) begin : g_size
    lane_shifter #(
      .DATA_W(DATA_W), .LANE_W(16 << s), .AMT_W(AMT_W), .FLAG_W(FLAG_W)
    ) u_lanes (
      .opnd(x), .amt(amt), .kind(strb.kind), .res(laneRes[s]), .nz(laneNz[s])
    );
  end

  logic [OFF_W-1:0]  byteOff;
  logic [SH_W-1:0]   bitOff;
  logic [DATA_W-1:0] alnRes;
  logic [DATA_W-1:0] nextRes;
  logic [FLAG_W-1:0] nextNz;

  always_comb begin
    byteOff = amt[OFF_W-1:0];
    bitOff  = {byteOff, 3'b000};
    if (byteOff == '0) alnRes = x;
    else alnRes = (x >> bitOff) | (y << (FULL - {1'b0, bitOff}));
    if (strb.align) begin
      nextRes = alnRes;
      nextNz  = '0;
    end else begin
      nextRes = laneRes[strb.laneIdx];
      nextNz  = laneNz[strb.laneIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ   <= '0;
      nzQ    <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.load;
      if (strb.load) begin
        resQ <= nextRes;
        nzQ  <= nextNz;
      end
    end
  end

  assert_valid_after_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> validQ);
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(resQ) && $stable(nzQ) && !validQ);
  assert_shl_oversize_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.align && strb.kind == KIND_SHL && strb.laneIdx == 2'd0 && amt >= 16
    |=> resQ == '0);
  assert_sar_sign_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.align && strb.kind == KIND_SAR && strb.laneIdx == 2'd2 && amt >= 64
    |=> resQ == {DATA_W{$past(x[DATA_W-1])}});
  assert_ror_full_turn_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.align && strb.kind == KIND_ROR && strb.laneIdx == 2'd0 && amt[3:0] == 4'd0
    |=> resQ == $past(x));
  assert_align_zero_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.align && amt[OFF_W-1:0] == '0 |=> resQ == $past(x));
  assert_align_flags_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.align |=> nzQ == '0);

endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8,
  localparam int FLAG_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic [1:0]        laneSel,
  input  logic [AMT_W-1:0]  amount,
  input  logic [DATA_W-1:0] opX,
  input  logic [DATA_W-1:0] opY,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] laneFlags,
  output logic              outValid
);
  import shifter_pkg::*;

  shStrobe_t strb;

  shifter_ctrl u_ctrl (
    .inValid(inValid), .opSel(opSel), .laneSel(laneSel), .strb(strb)
  );

  shifter_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W), .FLAG_W(FLAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .amt(amount), .x(opX), .y(opY),
    .resQ(result), .nzQ(laneFlags), .validQ(outValid)
  );

  assert_reserved_no_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opSel > 3'd4 |=> !outValid && $stable(result));

endmodule

// File: tb/simd_lane_shifter_bench.sv
`timescale 1ns/1ps
module simd_lane_shifter_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [2:0]  opSel;
  logic [1:0]  laneSel;
  logic [7:0]  amount;
  logic [63:0] opX, opY;
  logic [63:0] result;
  logic [31:0] laneFlags;
  logic        outValid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  simd_lane_shifter u_simd_lane_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .laneSel(laneSel),
    .amount(amount), .opX(opX), .opY(opY), .result(result),
    .laneFlags(laneFlags), .outValid(outValid)
  );

  localparam int NV = 20;
  localparam logic [63:0] PAT = 64'h8001_4000_00FF_1234;
  localparam logic [63:0] LO8 = 64'h0706_0504_0302_0100;
  localparam logic [63:0] HI8 = 64'h0F0E_0D0C_0B0A_0908;

  localparam logic [63:0] T_X [NV] = '{
    PAT, PAT, PAT, PAT, PAT, PAT, PAT,
    64'h0000_0001_8000_0000, 64'h0000_0001_8000_0000, 64'h8000_0000_7FFF_FFFF,
    64'h0000_0001_0000_0003, 64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000,
    LO8, LO8, LO8, LO8};
  localparam logic [7:0] T_AMT [NV] = '{
    8'd4, 8'd4, 8'd4, 8'd4, 8'd20, 8'd16, 8'd40, 8'd1, 8'd1, 8'd31,
    8'd1, 8'd1, 8'd63, 8'd64, 8'd68, 8'd1, 8'd3, 8'd0, 8'hF9, 8'd7};
  localparam logic [2:0] T_OP [NV] = '{
    3'd0, 3'd1, 3'd2, 3'd3, 3'd3, 3'd0, 3'd2, 3'd0, 3'd1, 3'd2,
    3'd3, 3'd0, 3'd2, 3'd1, 3'd3, 3'd0, 3'd4, 3'd4, 3'd4, 3'd4};
  localparam logic [1:0] T_LANE [NV] = '{
    2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1,
    2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic [63:0] T_EXP [NV] = '{
    64'h0010_0000_0FF0_2340, 64'h0800_0400_000F_0123, 64'hF800_0400_000F_0123,
    64'h1800_0400_F00F_4123, 64'h1800_0400_F00F_4123, 64'h0,
    64'hFFFF_0000_0000_0000, 64'h0000_0002_0000_0000, 64'h0000_0000_4000_0000,
    64'hFFFF_FFFF_0000_0000, 64'h8000_0000_8000_0001, 64'h0000_0001_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1000_0000_0000_0000,
    64'h0000_0001_0000_0000, 64'h0A09_0807_0605_0403, LO8,
    64'h0807_0605_0403_0201, 64'h0E0D_0C0B_0A09_0807};
  string vecTag [NV] = '{
    "R3", "R4", "R5", "R6", "R6", "R3", "R5", "R3", "R4", "R5",
    "R6", "R3", "R5", "R4", "R6", "R7", "R8", "R8", "R8", "R8"};

  // flag word from the R9 layout; align gives zero (R10)
  function automatic logic [31:0] flagModel(logic [63:0] r, logic [1:0] ln, logic aln);
    logic [31:0] f = '0;
    int lw = (ln == 2'd0) ? 16 : (ln == 2'd1) ? 32 : 64;
    int lanes = 64 / lw;
    int stride = 32 / lanes;
    if (aln) return '0;
    for (int i = 0; i < lanes; i++) begin
      logic [63:0] lv = (r >> (i * lw)) & ((lw == 64) ? '1 : ((64'd1 << lw) - 64'd1));
      f[stride*(i+1)-1] = lv[lw-1];
      f[stride*(i+1)-2] = (lv == 64'd0);
    end
    return f;
  endfunction

  task automatic check64(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [1:0] ln, logic [7:0] amt,
                       logic [63:0] x, logic [63:0] y);
    @(negedge clk);
    opSel = op; laneSel = ln; amount = amt; opX = x; opY = y; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] keepRes;
    logic [31:0] keepFlags;
    rstN = 1'b0; inValid = 1'b0; opSel = '0; laneSel = '0; amount = '0;
    opX = '0; opY = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check64("R1", "result", result, 64'h0);
    check64("R1", "flags", {32'h0, laneFlags}, 64'h0);
    check64("R1", "outValid", {63'h0, outValid}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check64("R1", "outValid after release", {63'h0, outValid}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      apply(T_OP[v], T_LANE[v], T_AMT[v], T_X[v], HI8);
      check64(vecTag[v], $sformatf("vec%0d result", v), result, T_EXP[v]);
      check64((T_OP[v] == 3'd4) ? "R10" : "R9", $sformatf("vec%0d flags", v),
              {32'h0, laneFlags}, {32'h0, flagModel(T_EXP[v], T_LANE[v], T_OP[v] == 3'd4)});
      check64("R2", $sformatf("vec%0d outValid", v), {63'h0, outValid}, 64'h1);
    end

    // R9 literal flag word: 16-bit lanes, top lane negative, others zero
    apply(3'd2, 2'd0, 8'd40, PAT, 64'h0);
    check64("R9", "literal flags", {32'h0, laneFlags}, 64'h8040_4040);
    // R9 64-bit lane, negative nonzero
    apply(3'd2, 2'd2, 8'd63, 64'h8000_0000_0000_0000, 64'h0);
    check64("R9", "dword flags", {32'h0, laneFlags}, 64'h8000_0000);

    // R2 hold when idle
    keepRes = result; keepFlags = laneFlags;
    @(negedge clk);
    opX = 64'h1234_5678_9ABC_DEF0; opSel = 3'd1; amount = 8'd3;
    @(negedge clk);
    check64("R2", "held result", result, keepRes);
    check64("R2", "held flags", {32'h0, laneFlags}, {32'h0, keepFlags});
    check64("R2", "idle outValid", {63'h0, outValid}, 64'h0);

    // R11 reserved operation codes
    for (int c = 5; c < 8; c++) begin
      apply(3'(c), 2'd0, 8'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      check64("R11", "reserved result", result, keepRes);
      check64("R11", "reserved flags", {32'h0, laneFlags}, {32'h0, keepFlags});
      check64("R11", "reserved outValid", {63'h0, outValid}, 64'h0);
    end

    // R1 reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check64("R1", "result after reset", result, 64'h0);
    check64("R1", "flags after reset", {32'h0, laneFlags}, 64'h0);
    rstN = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule